// File: doc/BRIEF.md
# Byte-Wide Access Port for 16-bit Counter and Compare Registers

This block holds a 16-bit up-counter and a 16-bit compare value and exposes both to an 8-bit register bus. Each 16-bit value has a low-byte address and a high-byte address. A single hidden staging byte lets software move whole 16-bit values through the narrow bus in two steps without tearing, even while the counter is running.

To write a value, software writes the high byte first. That byte only lands in the staging byte. It then writes the low byte, and both halves of the target register are updated on the same clock edge.

To read a value, software reads the low byte first. That returns the low half and also freezes the matching high half into the staging byte. It then reads the high byte, which returns the staging byte. The staging byte is common to both 16-bit registers, so the two-step sequences must not be interleaved between registers.

Read data is registered and appears one clock after the read request. The counter advances once per clock while the count enable is high.

Top module: `wide_reg_port`

## Requirements
- R1: After reset (`rst_n` low), `count_value`, `compare_value`, `bus_rdata` and the staging byte are all zero; a first read of a high-byte address returns 0x00.
- R2: While `count_en` is high and no counter low-byte write occurs, `count_value` rises by one per clock; while `count_en` is low and no counter low-byte write occurs, it holds.
- R3: The counter wraps from 0xFFFF to 0x0000.
- R4: A write to a high-byte address (1 = counter, 3 = compare) stores the data only in the staging byte and leaves both 16-bit registers unchanged.
- R5: A write to the counter low-byte address (0) sets `count_value` to {staging byte, data} on that edge, and takes priority over the increment in that cycle.
- R6: A read of a low-byte address (0 = counter, 2 = compare) returns that register's low byte on `bus_rdata` one clock later, and in the same edge copies that register's high byte into the staging byte.
- R7: A read of either high-byte address returns the staging byte rather than the live high byte, so a low-then-high read pair yields the counter value at the low-byte read even across a carry.
- R8: A write to the compare low-byte address (2) sets `compare_value` to {staging byte, data} and does not disturb the counter.
- R9: The staging byte is shared: staging through one register's high-byte address affects the other register's low-byte write, and a compare low-byte read followed by a counter high-byte read returns the compare high byte.
- R10: `bus_rdata` changes only on a read cycle (`bus_sel` high, `bus_we` low); writes and idle cycles leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| count_en | input | 1 | Counter advance enable |
| bus_sel | input | 1 | Bus access strobe, one access per cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | 0 counter low, 1 counter high, 2 compare low, 3 compare high |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| count_value | output | 16 | Live counter value |
| compare_value | output | 16 | Compare register value |

## Verification
Ordered write pairs are tried with the counter stopped. This separates staging from committing: the counter must not move after the high-byte write and must show the full value after the low-byte write. Read pairs are issued while the counter crosses a byte carry, which shows whether the high-byte read returns the frozen or the live half. Cross-register sequences (stage through one register, commit or read through the other) show whether the staging byte is truly shared. A low-byte write on an enabled cycle and a run over 0xFFFF cover increment priority and wrap.

// File: rtl/wrp_pkg.sv
package wrp_pkg;
    localparam int BYTE_W = 8;
    localparam int WIDE_W = 2 * BYTE_W;
    localparam int ADDR_W = 2;

    localparam logic [ADDR_W-1:0] A_CNT_LO = 2'd0;
    localparam logic [ADDR_W-1:0] A_CNT_HI = 2'd1;
    localparam logic [ADDR_W-1:0] A_CMP_LO = 2'd2;
    localparam logic [ADDR_W-1:0] A_CMP_HI = 2'd3;

    typedef enum logic [2:0] {
        ACC_IDLE,
        ACC_CNT_LO_WR,
        ACC_CNT_LO_RD,
        ACC_CMP_LO_WR,
        ACC_CMP_LO_RD,
        ACC_HI_WR,
        ACC_HI_RD
    } access_e;
endpackage

// File: rtl/wrp_access_decode.sv
module wrp_access_decode
    import wrp_pkg::*;
(
    input  logic              sel,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    output access_e           acc
);
    always_comb begin
        acc = ACC_IDLE;
        if (sel) begin
            unique case (addr)
                A_CNT_LO: acc = we ? ACC_CNT_LO_WR : ACC_CNT_LO_RD;
                A_CMP_LO: acc = we ? ACC_CMP_LO_WR : ACC_CMP_LO_RD;
                A_CNT_HI,
                A_CMP_HI: acc = we ? ACC_HI_WR : ACC_HI_RD;
                default:  acc = ACC_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/wrp_stage_byte.sv
module wrp_stage_byte #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] din,
    output logic [W-1:0] q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    q <= '0;
        else if (load) q <= din;
    end
endmodule

// File: rtl/wrp_wide_reg.sv
module wrp_wide_reg #(
    parameter int W         = 16,
    parameter bit COUNTING  = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    input  logic         load,
    input  logic [W-1:0] din,
    output logic [W-1:0] q
);
    generate
        if (COUNTING) begin : g_count
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)     q <= '0;
                else if (load)  q <= din;
                else if (inc)   q <= q + {{(W-1){1'b0}}, 1'b1};
            end
        end else begin : g_hold
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)     q <= '0;
                else if (load)  q <= din;
            end
            logic unused_inc;
            assign unused_inc = inc;
        end
    endgenerate
endmodule

// File: rtl/wide_reg_port.sv
module wide_reg_port
    import wrp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              count_en,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [1:0]        bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    output logic [15:0]       count_value,
    output logic [15:0]       compare_value
);
    access_e            acc;
    logic               stage_load;
    logic [BYTE_W-1:0]  stage_din;
    logic [BYTE_W-1:0]  stage_q;
    logic [BYTE_W-1:0]  rdata_d;
    logic               rdata_en;

    wrp_access_decode u_dec (
        .sel  (bus_sel),
        .we   (bus_we),
        .addr (bus_addr),
        .acc  (acc)
    );

    // Staging byte source selection
    always_comb begin
        stage_load = 1'b0;
        stage_din  = bus_wdata;
        rdata_en   = 1'b0;
        rdata_d    = bus_rdata;
        unique case (acc)
            ACC_HI_WR: begin
                stage_load = 1'b1;
                stage_din  = bus_wdata;
            end
            ACC_CNT_LO_RD: begin
                stage_load = 1'b1;
                stage_din  = count_value[WIDE_W-1:BYTE_W];
                rdata_en   = 1'b1;
                rdata_d    = count_value[BYTE_W-1:0];
            end
            ACC_CMP_LO_RD: begin
                stage_load = 1'b1;
                stage_din  = compare_value[WIDE_W-1:BYTE_W];
                rdata_en   = 1'b1;
                rdata_d    = compare_value[BYTE_W-1:0];
            end
            ACC_HI_RD: begin
                rdata_en   = 1'b1;
                rdata_d    = stage_q;
            end
            default: ;
        endcase
    end

    wrp_stage_byte #(.W(BYTE_W)) u_stage (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (stage_load),
        .din   (stage_din),
        .q     (stage_q)
    );

    wrp_wide_reg #(.W(WIDE_W), .COUNTING(1'b1)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (count_en),
        .load  (acc == ACC_CNT_LO_WR),
        .din   ({stage_q, bus_wdata}),
        .q     (count_value)
    );

    wrp_wide_reg #(.W(WIDE_W), .COUNTING(1'b0)) u_cmp (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (1'b0),
        .load  (acc == ACC_CMP_LO_WR),
        .din   ({stage_q, bus_wdata}),
        .q     (compare_value)
    );

    // Registered read data
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        bus_rdata <= '0;
        else if (rdata_en) bus_rdata <= rdata_d;
    end
endmodule

// File: rtl/wide_reg_port_chk.sv
module wide_reg_port_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        count_en,
    input logic        bus_sel,
    input logic        bus_we,
    input logic [1:0]  bus_addr,
    input logic [7:0]  bus_wdata,
    input logic [7:0]  bus_rdata,
    input logic [15:0] count_value,
    input logic [15:0] compare_value
);
    logic cnt_lo_wr, cmp_lo_wr, cnt_lo_rd, hi_wr, any_rd;
    assign cnt_lo_wr = bus_sel && bus_we && (bus_addr == 2'd0);
    assign cmp_lo_wr = bus_sel && bus_we && (bus_addr == 2'd2);
    assign cnt_lo_rd = bus_sel && !bus_we && (bus_addr == 2'd0);
    assign hi_wr     = bus_sel && bus_we && bus_addr[0];
    assign any_rd    = bus_sel && !bus_we;

    assert_count_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (count_en && !cnt_lo_wr) |=> (count_value == $past(count_value) + 16'd1));

    assert_count_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!count_en && !cnt_lo_wr) |=> $stable(count_value));

    assert_hi_write_no_commit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (hi_wr && !count_en) |=> ($stable(count_value) && $stable(compare_value)));

    assert_lo_write_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_lo_wr |=> (count_value[7:0] == $past(bus_wdata)));

    assert_cmp_write_only_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !cmp_lo_wr |=> $stable(compare_value));

    assert_lo_read_data_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_lo_rd |=> (bus_rdata == $past(count_value[7:0])));

    assert_rdata_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !any_rd |=> $stable(bus_rdata));
endmodule

bind wide_reg_port wide_reg_port_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .count_en      (count_en),
    .bus_sel       (bus_sel),
    .bus_we        (bus_we),
    .bus_addr      (bus_addr),
    .bus_wdata     (bus_wdata),
    .bus_rdata     (bus_rdata),
    .count_value   (count_value),
    .compare_value (compare_value)
);

// File: tb/sim_wide_reg_port.sv
module sim_wide_reg_port;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        count_en = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_we = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [7:0]  bus_wdata = 8'd0;
    logic [7:0]  bus_rdata;
    logic [15:0] count_value;
    logic [15:0] compare_value;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 1'b0;
    bit rd_seen = 1'b0;

    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #5 clk = ~clk;

    wide_reg_port u0 (
        .clk           (clk),
        .rst_n         (rst_n),
        .count_en      (count_en),
        .bus_sel       (bus_sel),
        .bus_we        (bus_we),
        .bus_addr      (bus_addr),
        .bus_wdata     (bus_wdata),
        .bus_rdata     (bus_rdata),
        .count_value   (count_value),
        .compare_value (compare_value)
    );

    task automatic check16(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Monitor: pop one expected byte per completed read
    always @(posedge clk) rd_seen <= bus_sel && !bus_we && rst_n;
    always @(negedge clk) begin
        if (rd_seen) begin
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL R6: actual=%h expected=<none>", bus_rdata);
            end else begin
                logic [7:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (bus_rdata !== e) begin
                    errors++;
                    $display("FAIL %s: actual=%h expected=%h", t, bus_rdata, e);
                end
            end
        end
    end

    // Driver tasks: called at a falling edge, return at the next falling edge
    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, input logic [7:0] e, input string req);
        exp_q.push_back(e); tag_q.push_back(req);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        @(posedge clk); @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin @(posedge clk); @(negedge clk); end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            done = 1'b1;
            errors++; checks++;
            $display("FAIL watchdog: actual=%0d expected<100000", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    logic [7:0] held;

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check16("R1", count_value, 16'h0000);
        check16("R1", compare_value, 16'h0000);
        check16("R1", {8'h00, bus_rdata}, 16'h0000);
        rst_n = 1'b1;
        @(negedge clk);
        rd(2'd1, 8'h00, "R1");

        // R4/R5: staged write with counter stopped
        wr(2'd1, 8'h12);
        check16("R4", count_value, 16'h0000);
        check16("R4", compare_value, 16'h0000);
        rd(2'd3, 8'h12, "R4");
        wr(2'd0, 8'h34);
        check16("R5", count_value, 16'h1234);

        // R6/R7: ordered read pair
        rd(2'd0, 8'h34, "R6");
        rd(2'd1, 8'h12, "R7");

        // R8: compare write
        wr(2'd3, 8'hAB);
        wr(2'd2, 8'hCD);
        check16("R8", compare_value, 16'hABCD);
        check16("R8", count_value, 16'h1234);

        // R9: shared staging byte
        wr(2'd1, 8'h77);
        wr(2'd2, 8'h01);
        check16("R9", compare_value, 16'h7701);
        check16("R9", count_value, 16'h1234);
        rd(2'd2, 8'h01, "R9");
        rd(2'd1, 8'h77, "R9");
        rd(2'd0, 8'h34, "R9");
        rd(2'd3, 8'h12, "R9");

        // R2: hold while disabled
        idle(4);
        check16("R2", count_value, 16'h1234);

        // R7: read pair across a carry
        wr(2'd1, 8'h12);
        wr(2'd0, 8'hFE);
        count_en = 1'b1;
        rd(2'd0, 8'hFE, "R7");
        rd(2'd1, 8'h12, "R7");
        count_en = 1'b0;
        check16("R2", count_value, 16'h1300);

        // R5: low write wins over increment
        wr(2'd1, 8'h55);
        count_en = 1'b1;
        wr(2'd0, 8'h66);
        count_en = 1'b0;
        check16("R5", count_value, 16'h5566);

        // R2/R3: run and wrap
        wr(2'd1, 8'hFF);
        wr(2'd0, 8'hFE);
        count_en = 1'b1;
        idle(1);
        check16("R3", count_value, 16'hFFFF);
        idle(1);
        check16("R3", count_value, 16'h0000);
        idle(3);
        count_en = 1'b0;
        check16("R2", count_value, 16'h0003);

        // R10: rdata holds across writes and idle cycles
        rd(2'd2, 8'h01, "R10");
        held = bus_rdata;
        wr(2'd3, 8'h99);
        idle(2);
        check16("R10", {8'h00, bus_rdata}, {8'h00, held});
        check16("R10", compare_value, 16'h7701);

        idle(2);
        check16("R6", {8'h00, 8'(exp_q.size())}, 16'h0000);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule